// File: doc/BRIEF.md
# Tagged Non-Blocking Read Requester

This block turns a stream of element offsets into read requests toward a host-memory port. Each request goes out at the physical address formed from a shared base address plus the offset. Each request carries a tag that no other in-flight request holds. A new request is issued as soon as an offset arrives. The block never waits for earlier reads to complete, so up to TAGS reads can be outstanding at once.

Responses come back as (data, tag) pairs in any order. The block looks up the tag in an outstanding table that holds the offset each request was issued for. It then presents the result as an (offset, data) pair and returns the tag to the free pool.

A response whose tag is not outstanding is dropped and raises a sticky error flag. A one-cycle done pulse marks the point where the stream's last beat has been accepted and every tag has been retired.

The offset input, the request output, the response input and the result output are valid/ready streams. Request and result paths are combinational pass-throughs with no storage at the edge.

Back-pressure works as follows:
- `req_ready` low stalls the offset input.
- The offset input also stalls while every tag is in use.
- `res_ready` low stalls the response input for responses whose tag is outstanding.
- Responses with an unknown tag are always accepted.

Top module: `tagged_read_requester`

## Requirements
- R1: `req_addr` equals `base_addr` plus the zero-extended `off_data`, modulo 2^ADDR_W, in the same cycle as `req_valid`.
- R2: The tag issued on `req_tag` is the lowest-numbered tag not currently in flight. A tag is never issued while it is in flight.
- R3: When at least one tag is free, `req_valid` equals `off_valid` and `off_ready` equals `req_ready` in the same cycle, whatever responses are pending. An offset is consumed exactly when `off_valid` and `off_ready` are both high.
- R4: A response with an in-flight tag produces `res_valid` in the same cycle. `res_offset` is the offset recorded for that tag and `res_data` equals `rsp_data`. `rsp_ready` equals `res_ready`. On the handshake the tag is freed and can be issued from the next cycle. Responses may retire in any order.
- R5: While all TAGS tags are in flight, `off_ready` and `req_valid` are low.
- R6: A response whose tag is not in flight is accepted (`rsp_ready` high) with `res_valid` low. `err_unknown_tag` rises in the next cycle and stays high until reset.
- R7: `done` is a single-cycle pulse. It rises one cycle after a cycle in which an accepted `off_last` beat is pending and no tag is in flight. The pending last beat is then cleared.
- R8: After reset no tag is in flight, `err_unknown_tag` and `done` are low, and tag 0 is the next one issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_addr | input | ADDR_W | Base address added to every offset |
| off_valid | input | 1 | Offset stream valid |
| off_ready | output | 1 | Offset stream ready |
| off_data | input | OFF_W | Element offset |
| off_last | input | 1 | Marks the final offset of a stream |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Read request ready |
| req_addr | output | ADDR_W | Physical read address |
| req_tag | output | TAG_W | Request tag |
| rsp_valid | input | 1 | Response valid |
| rsp_ready | output | 1 | Response ready |
| rsp_data | input | DATA_W | Response payload |
| rsp_tag | input | TAG_W | Tag the response answers |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result ready |
| res_offset | output | OFF_W | Offset the result belongs to |
| res_data | output | DATA_W | Result payload |
| err_unknown_tag | output | 1 | Sticky: a response with an unknown tag was seen |
| done | output | 1 | One-cycle pulse when the stream's reads have all retired |

## Verification
The assertions assume the following about the inputs:
- `base_addr` does not change while requests for a stream are being issued.
- The memory side never produces a response before the request that carries its tag has been handshaken.

The tag-pool and done checks rely only on the block's own handshakes.

The stimulus drives responses only for tags that its reference model holds as in flight, except for deliberate unknown-tag responses that exercise the error flag. `base_addr` is changed only between phases.

// File: rtl/trr_pkg.sv
package trr_pkg;
  localparam int unsigned TRR_DEF_ADDR_W = 32;
  localparam int unsigned TRR_DEF_OFF_W  = 16;
  localparam int unsigned TRR_DEF_DATA_W = 32;
  localparam int unsigned TRR_DEF_TAGS   = 16;
endpackage

// File: rtl/trr_tag_pool.sv
module trr_tag_pool #(
  parameter int unsigned TAGS  = 16,
  parameter int unsigned TAG_W = $clog2(TAGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  logic             free_en,
  input  logic [TAG_W-1:0] free_tag,
  output logic             avail,
  output logic [TAG_W-1:0] alloc_tag,
  output logic [TAGS-1:0]  busy
);
  logic [TAG_W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = TAGS - 1; i >= 0; i--) begin
      if (!busy[i]) pick = TAG_W'(i);
    end
  end

  assign avail     = ~&busy;
  assign alloc_tag = pick;

  for (genvar g = 0; g < TAGS; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy[g] <= 1'b0;
      end else if (alloc_en && alloc_tag == TAG_W'(g)) begin
        busy[g] <= 1'b1;
      end else if (free_en && free_tag == TAG_W'(g)) begin
        busy[g] <= 1'b0;
      end
    end
  end

  // R2: a tag handed out is never one already in flight
  assert_alloc_unique_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !busy[alloc_tag]);

  // R2: an allocated tag is held in flight afterwards
  assert_alloc_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |=> busy[$past(alloc_tag)]);

  // R4: a freed tag is available in the following cycle
  assert_free_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    free_en |=> !busy[$past(free_tag)]);
endmodule

// File: rtl/trr_offset_table.sv
module trr_offset_table #(
  parameter int unsigned TAGS  = 16,
  parameter int unsigned TAG_W = $clog2(TAGS),
  parameter int unsigned OFF_W = 16
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [TAG_W-1:0] rd_tag,
  output logic [OFF_W-1:0] rd_off
);
  logic [OFF_W-1:0] entry [TAGS];

  for (genvar g = 0; g < TAGS; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (wr_en && wr_tag == TAG_W'(g)) entry[g] <= wr_off;
    end
  end

  always_comb begin
    rd_off = '0;
    for (int i = 0; i < TAGS; i++) begin
      if (rd_tag == TAG_W'(i)) rd_off = entry[i];
    end
  end
endmodule

// File: rtl/trr_done_tracker.sv
module trr_done_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic last_acc,
  input  logic idle,
  output logic done
);
  logic last_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_pend <= 1'b0;
      done      <= 1'b0;
    end else begin
      done      <= last_pend && idle;
      last_pend <= (last_pend && !idle) || last_acc;
    end
  end

  // R7: done lasts one cycle only
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/tagged_read_requester.sv
module tagged_read_requester
  import trr_pkg::*;
#(
  parameter int unsigned ADDR_W = TRR_DEF_ADDR_W,
  parameter int unsigned OFF_W  = TRR_DEF_OFF_W,
  parameter int unsigned DATA_W = TRR_DEF_DATA_W,
  parameter int unsigned TAGS   = TRR_DEF_TAGS,
  localparam int unsigned TAG_W = $clog2(TAGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              off_valid,
  output logic              off_ready,
  input  logic [OFF_W-1:0]  off_data,
  input  logic              off_last,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [TAG_W-1:0]  req_tag,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic [TAG_W-1:0]  rsp_tag,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [OFF_W-1:0]  res_offset,
  output logic [DATA_W-1:0] res_data,
  output logic              err_unknown_tag,
  output logic              done
);
  logic            avail;
  logic [TAGS-1:0] busy;
  logic            issue;
  logic            known;
  logic            retire;
  logic            stray;

  assign known = ({1'b0, rsp_tag} < (TAG_W + 1)'(TAGS)) && busy[rsp_tag];

  assign req_valid = off_valid && avail;
  assign off_ready = req_ready && avail;
  assign req_addr  = base_addr + ADDR_W'(off_data);
  assign issue     = off_valid && off_ready;

  assign res_valid = rsp_valid && known;
  assign res_data  = rsp_data;
  assign rsp_ready = known ? res_ready : 1'b1;
  assign retire    = res_valid && res_ready;
  assign stray     = rsp_valid && !known;

  trr_tag_pool #(.TAGS(TAGS), .TAG_W(TAG_W)) pool_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(issue), .free_en(retire), .free_tag(rsp_tag),
    .avail(avail), .alloc_tag(req_tag), .busy(busy)
  );

  trr_offset_table #(.TAGS(TAGS), .TAG_W(TAG_W), .OFF_W(OFF_W)) table_i (
    .clk(clk), .wr_en(issue), .wr_tag(req_tag), .wr_off(off_data),
    .rd_tag(rsp_tag), .rd_off(res_offset)
  );

  trr_done_tracker done_i (
    .clk(clk), .rst_n(rst_n),
    .last_acc(issue && off_last), .idle(busy == '0),
    .done(done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     err_unknown_tag <= 1'b0;
    else if (stray) err_unknown_tag <= 1'b1;
  end

  // R5: no offset is taken while every tag is in flight
  assert_full_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (&busy) |-> (!off_ready && !req_valid));

  // R6: the error flag never falls outside reset
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_unknown_tag |=> err_unknown_tag);

  // R6: an unknown-tag response always raises the flag
  assert_stray_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stray |=> err_unknown_tag);

  // R3: with a free tag, an offset goes straight out when the port is ready
  assert_no_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (off_valid && req_ready && !(&busy)) |-> (off_ready && req_valid));
endmodule

// File: tb/tagged_read_requester_tb_top.sv
`timescale 1ns/1ps
module tagged_read_requester_tb_top;
  localparam int AW = 32, OW = 16, DW = 32, NT = 16, TW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [AW-1:0] base_addr = '0;
  logic off_valid = 0, off_last = 0, req_ready = 0, rsp_valid = 0, res_ready = 0;
  logic [OW-1:0] off_data = '0;
  logic [DW-1:0] rsp_data = '0;
  logic [TW-1:0] rsp_tag = '0;
  logic off_ready, req_valid, rsp_ready, res_valid, err_unknown_tag, done;
  logic [AW-1:0] req_addr;
  logic [TW-1:0] req_tag;
  logic [OW-1:0] res_offset;
  logic [DW-1:0] res_data;

  tagged_read_requester dut_i (
    .clk(clk), .rst_n(rst_n), .base_addr(base_addr),
    .off_valid(off_valid), .off_ready(off_ready), .off_data(off_data), .off_last(off_last),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_tag(req_tag),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_tag(rsp_tag),
    .res_valid(res_valid), .res_ready(res_ready), .res_offset(res_offset), .res_data(res_data),
    .err_unknown_tag(err_unknown_tag), .done(done)
  );

  int checks = 0, bad = 0;
  bit m_busy [NT];
  int m_off [NT];
  bit m_last = 0, m_err = 0, m_done = 0;
  int dones = 0;

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int m_free();
    for (int i = 0; i < NT; i++) if (!m_busy[i]) return i;
    return -1;
  endfunction

  function automatic int m_count();
    int c = 0;
    for (int i = 0; i < NT; i++) if (m_busy[i]) c++;
    return c;
  endfunction

  task automatic compare();
    int  f;
    bit  known, e_rv;
    f = m_free();
    known = m_busy[rsp_tag];
    e_rv = rsp_valid && known;
    chk("R3", "off_ready", off_ready, req_ready && f >= 0);
    chk("R3", "req_valid", req_valid, off_valid && f >= 0);
    if (f < 0 && off_valid) chk("R5", "off_ready full", off_ready, 0);
    if (off_valid && f >= 0) begin
      chk("R2", "req_tag", req_tag, f);
      chk("R1", "req_addr", req_addr, (base_addr + {16'h0, off_data}) & 32'hFFFF_FFFF);
    end
    chk(rsp_valid && !known ? "R6" : "R4", "res_valid", res_valid, e_rv);
    chk("R4", "rsp_ready", rsp_ready, known ? res_ready : 1'b1);
    if (e_rv) begin
      chk("R4", "res_offset", res_offset, m_off[rsp_tag]);
      chk("R4", "res_data", res_data, rsp_data);
    end
    chk("R6", "err_unknown_tag", err_unknown_tag, m_err);
    chk("R7", "done", done, m_done);
  endtask

  task automatic model_step();
    bit acc, fre, unk, any;
    int f;
    f = m_free();
    if (!rst_n) begin
      for (int i = 0; i < NT; i++) m_busy[i] = 0;
      m_last = 0; m_err = 0; m_done = 0;
      return;
    end
    acc = off_valid && req_ready && f >= 0;
    fre = rsp_valid && m_busy[rsp_tag] && res_ready;
    unk = rsp_valid && !m_busy[rsp_tag];
    any = m_count() != 0;
    m_done = m_last && !any;
    if (m_done) dones++;
    m_last = (m_last && any) || (acc && off_last);
    if (unk) m_err = 1;
    if (fre) m_busy[rsp_tag] = 0;
    if (acc) begin m_busy[f] = 1; m_off[f] = off_data; end
  endtask

  task automatic cyc();
    #1;
    if (rst_n) compare();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic idle_in();
    off_valid = 0; off_last = 0; rsp_valid = 0;
  endtask

  task automatic respond(input int tag, input logic [DW-1:0] d);
    rsp_valid = 1; rsp_tag = TW'(tag); rsp_data = d;
  endtask

  task automatic send(input int off, input bit last);
    off_valid = 1; off_data = OW'(off); off_last = last;
  endtask

  initial begin
    #1000000;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    for (int i = 0; i < 3; i++) cyc();
    rst_n = 1;
    #1;
    // R8: state right after reset
    chk("R8", "err after reset", err_unknown_tag, 0);
    chk("R8", "done after reset", done, 0);
    chk("R8", "first tag", req_tag, 0);
    @(negedge clk);

    // R1/R2/R3: three back-to-back requests, no responses yet
    base_addr = 32'h1000_0000; req_ready = 1; res_ready = 1;
    send(5, 0); cyc();
    send(9, 0); cyc();
    send(16'hFFFF, 1); cyc();
    idle_in();
    chk("R2", "three tags held", m_count(), 3);
    cyc();

    // R4: responses out of order
    respond(2, 32'hC2); cyc();
    respond(0, 32'hA0); cyc();
    // R4: result port stalled holds the response
    res_ready = 0; respond(1, 32'hB1); cyc(); cyc();
    res_ready = 1; cyc();
    idle_in(); cyc(); cyc();
    chk("R7", "done seen once", dones, 1);

    // R6: unknown tag response
    respond(7, 32'hDEAD); cyc();
    idle_in(); cyc(); cyc();

    // R1: address wrap with large base
    base_addr = 32'hFFFF_FFF0;
    send(16'h0020, 0); cyc();
    idle_in(); respond(0, 32'h55); cyc();
    idle_in();

    // R5: fill every tag, then R2 reuses the lowest freed tag
    base_addr = 32'h0000_4000;
    for (int i = 0; i < NT + 2; i++) begin send(100 + i, 0); cyc(); end
    chk("R5", "all tags held", m_count(), NT);
    idle_in(); respond(6, 32'h66); cyc();
    respond(3, 32'h33); send(200, 0); cyc();
    idle_in(); send(201, 0); cyc();
    // R3: request port stall
    req_ready = 0; send(202, 0); cyc(); cyc();
    req_ready = 1; idle_in();
    for (int i = 0; i < NT; i++) begin
      if (m_busy[i]) begin respond(i, 32'h9000 + i); cyc(); end
    end
    idle_in(); cyc();

    // random traffic with drain and done
    for (int n = 0; n < 1500; n++) begin
      int pick;
      off_valid = ($urandom % 10) < 6;
      off_data = OW'($urandom);
      off_last = ($urandom % 40) == 0;
      req_ready = ($urandom % 10) < 8;
      res_ready = ($urandom % 10) < 8;
      rsp_valid = 0;
      pick = $urandom % NT;
      if (($urandom % 2) == 1 && m_busy[pick]) respond(pick, $urandom);
      else if (($urandom % 60) == 0) respond(pick, $urandom);
      base_addr = 32'h2000_0000;
      cyc();
    end
    idle_in(); res_ready = 1;
    send(1, 1); cyc(); idle_in();
    for (int k = 0; k < 4 * NT && m_count() != 0; k++) begin
      for (int i = 0; i < NT; i++) if (m_busy[i]) begin respond(i, 32'h7); break; end
      cyc();
    end
    idle_in(); cyc(); cyc(); cyc();
    chk("R7", "drained", m_count(), 0);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule